// File: doc/BRIEF.md
# Prioritised Exception Entry Controller

This block decides which exception a processor core enters when several requests are raised together, and it produces everything the core needs for the entry in one registered bundle. The bundle holds the handler vector address, the new mode bits, the new interrupt-mask and instruction-state bits, the return address for the link register, and a copy of the status word that was current before the entry. The core supplies its current program counter, status bits and an instruction-boundary strobe. The block answers with a one-cycle entry pulse that carries the bundle.

The two active-low interrupt lines pass through a synchronizer with a configurable number of stages, unless the bypass input says the lines are already synchronous. The normal interrupt is masked by the I flag and the fast interrupt by the F flag. Every request except the reset request is evaluated only when the boundary strobe is high. A data abort that wins while an enabled fast interrupt is also present is followed, in the very next cycle, by a fast-interrupt entry.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While `rst_req` is high, no entry is produced. In the cycle after the first cycle with `rst_req` low, there is a reset entry: kind 1, vector 0, mode 5'b10011, I=1, F=1, T=0, link 0. This entry wins over every other request.
- R2: When several requests are present at a boundary, the one taken is the first in this order: data abort, enabled fast interrupt, enabled interrupt, prefetch abort, undefined, software interrupt.
- R3: Vector offsets are undefined 0x04, software interrupt 0x08, prefetch abort 0x0C, data abort 0x10, interrupt 0x18 and fast interrupt 0x1C, each zero-extended to `ADDR_W` bits.
- R4: The new mode is 10011 for software interrupt, 11011 for undefined, 10111 for either abort, 10010 for interrupt and 10001 for fast interrupt.
- R5: `entry_link` is `cur_pc` plus 8 for a data abort and plus 4 for an interrupt, a fast interrupt or a prefetch abort. For undefined and software interrupt it is plus 4 when `cur_t`=0 and plus 2 when `cur_t`=1. The sum wraps modulo 2^`ADDR_W`.
- R6: Every entry clears T and sets I. A fast-interrupt entry and a reset entry also set F. Any other entry copies F from `cur_f`.
- R7: `entry_saved` holds the status word from before the entry: bit 7 = I, bit 6 = F, bit 5 = T, bits 4:0 = mode. It is sampled from the `cur_*` inputs in the request cycle, except for a chained entry (R11).
- R8: An interrupt request is not taken while `cur_i`=1. A fast-interrupt request is not taken while `cur_f`=1.
- R9: With `sync_bypass`=0, a level on `irq_n` or `fiq_n` reaches the priority logic `SYNC_STAGES` cycles later. With `sync_bypass`=1, it reaches the priority logic in the same cycle.
- R10: With `boundary`=0, no request other than reset release and a chained entry produces an entry.
- R11: If a data abort wins while an enabled fast interrupt is present, the next cycle carries a fast-interrupt entry with link 0x14 and saved word {I=1, F=0, T=0, mode 10111}.
- R12: Outputs are registered. An entry appears in the cycle after its request cycle, and `entry_vld` is high for exactly that cycle. `entry_kind` is 0 when there is no entry. Otherwise it is 1 reset, 2 data abort, 3 fast interrupt, 4 interrupt, 5 prefetch abort, 6 undefined, 7 software interrupt. Block reset `rst` clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| rst_req | input | 1 | Core reset request; entry on release |
| boundary | input | 1 | Instruction-boundary strobe |
| irq_n | input | 1 | Active-low interrupt request |
| fiq_n | input | 1 | Active-low fast interrupt request |
| sync_bypass | input | 1 | High: interrupt lines skip the synchronizer |
| dabt_req | input | 1 | Data abort request |
| pabt_req | input | 1 | Prefetch abort request |
| und_req | input | 1 | Undefined instruction request |
| swi_req | input | 1 | Software interrupt request |
| cur_i | input | 1 | Current interrupt mask |
| cur_f | input | 1 | Current fast-interrupt mask |
| cur_t | input | 1 | Current 16-bit state flag |
| cur_mode | input | 5 | Current mode bits |
| cur_pc | input | ADDR_W | Current program counter |
| entry_vld | output | 1 | Entry pulse |
| entry_kind | output | 3 | Code of the exception taken |
| entry_vec | output | ADDR_W | Handler vector address |
| entry_mode | output | 5 | New mode bits |
| entry_i | output | 1 | New interrupt mask |
| entry_f | output | 1 | New fast-interrupt mask |
| entry_t | output | 1 | New state flag |
| entry_link | output | ADDR_W | Value for the link register |
| entry_saved | output | 8 | Status word before the entry |

## Verification
The bench builds the block with `ADDR_W`=16 and `SYNC_STAGES`=3. The narrow address lets a data-abort program counter near 0xFFFE show the link wrap-around. The three-stage synchronizer makes the delay of a held interrupt level visibly longer than one cycle against the bypassed path. The reference model reproduces the synchronizer lag, the boundary gating and the data-abort-then-fast-interrupt chaining on every clock.

// File: rtl/exc_pkg.sv
package exc_pkg;

    typedef enum logic [2:0] {
        EXC_NONE = 3'd0,
        EXC_RST  = 3'd1,
        EXC_DABT = 3'd2,
        EXC_FIQ  = 3'd3,
        EXC_IRQ  = 3'd4,
        EXC_PABT = 3'd5,
        EXC_UND  = 3'd6,
        EXC_SWI  = 3'd7
    } exc_kind_e;

    typedef struct packed {
        logic       i;
        logic       f;
        logic       t;
        logic [4:0] mode;
    } psr_t;

    localparam logic [4:0] MODE_FIQ = 5'b10001;
    localparam logic [4:0] MODE_IRQ = 5'b10010;
    localparam logic [4:0] MODE_SVC = 5'b10011;
    localparam logic [4:0] MODE_ABT = 5'b10111;
    localparam logic [4:0] MODE_UND = 5'b11011;

    function automatic logic [4:0] vec_off(exc_kind_e k);
        case (k)
            EXC_UND:  return 5'h04;
            EXC_SWI:  return 5'h08;
            EXC_PABT: return 5'h0C;
            EXC_DABT: return 5'h10;
            EXC_IRQ:  return 5'h18;
            EXC_FIQ:  return 5'h1C;
            default:  return 5'h00;
        endcase
    endfunction

    function automatic logic [4:0] mode_of(exc_kind_e k);
        case (k)
            EXC_FIQ:            return MODE_FIQ;
            EXC_IRQ:            return MODE_IRQ;
            EXC_DABT, EXC_PABT: return MODE_ABT;
            EXC_UND:            return MODE_UND;
            default:            return MODE_SVC;
        endcase
    endfunction

    function automatic logic [3:0] link_off(exc_kind_e k, logic thumb);
        case (k)
            EXC_DABT:                   return 4'd8;
            EXC_FIQ, EXC_IRQ, EXC_PABT: return 4'd4;
            EXC_UND, EXC_SWI:           return thumb ? 4'd2 : 4'd4;
            default:                    return 4'd0;
        endcase
    endfunction

endpackage

// File: rtl/exc_sync.sv
module exc_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bypass,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage [STAGES+1];

    assign stage[0] = din;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage[g+1] <= '1;
            else     stage[g+1] <= stage[g];
        end
    end

    assign dout = bypass ? din : stage[STAGES];
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_pkg::*;
(
    input  logic      boundary,
    input  logic      dabt,
    input  logic      fiq_en,
    input  logic      irq_en,
    input  logic      pabt,
    input  logic      und,
    input  logic      swi,
    output exc_kind_e win
);
    always_comb begin
        win = EXC_NONE;
        if (boundary) begin
            if (dabt)        win = EXC_DABT;
            else if (fiq_en) win = EXC_FIQ;
            else if (irq_en) win = EXC_IRQ;
            else if (pabt)   win = EXC_PABT;
            else if (und)    win = EXC_UND;
            else if (swi)    win = EXC_SWI;
        end
    end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rst_req,
    input  logic              boundary,
    input  logic              irq_n,
    input  logic              fiq_n,
    input  logic              sync_bypass,
    input  logic              dabt_req,
    input  logic              pabt_req,
    input  logic              und_req,
    input  logic              swi_req,
    input  logic              cur_i,
    input  logic              cur_f,
    input  logic              cur_t,
    input  logic [4:0]        cur_mode,
    input  logic [ADDR_W-1:0] cur_pc,
    output logic              entry_vld,
    output logic [2:0]        entry_kind,
    output logic [ADDR_W-1:0] entry_vec,
    output logic [4:0]        entry_mode,
    output logic              entry_i,
    output logic              entry_f,
    output logic              entry_t,
    output logic [ADDR_W-1:0] entry_link,
    output logic [7:0]        entry_saved
);
    localparam logic [ADDR_W-1:0] DABT_BASE = ADDR_W'(vec_off(EXC_DABT));

    logic [1:0] lines_s;
    logic       irq_en, fiq_en;
    exc_kind_e  win, sel;
    logic       rq_q, chain_q, chain_nxt;
    logic [ADDR_W-1:0] base_pc;
    logic       base_t;
    psr_t       old_psr;

    exc_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .bypass (sync_bypass),
        .din    ({fiq_n, irq_n}),
        .dout   (lines_s)
    );

    assign irq_en = !lines_s[0] && !cur_i;
    assign fiq_en = !lines_s[1] && !cur_f;

    exc_arbiter u_arb (
        .boundary (boundary),
        .dabt     (dabt_req),
        .fiq_en   (fiq_en),
        .irq_en   (irq_en),
        .pabt     (pabt_req),
        .und      (und_req),
        .swi      (swi_req),
        .win      (win)
    );

    always_comb begin
        sel     = EXC_NONE;
        base_pc = cur_pc;
        base_t  = cur_t;
        old_psr = '{i: cur_i, f: cur_f, t: cur_t, mode: cur_mode};
        if (rst_req) begin
            sel = EXC_NONE;
        end else if (rq_q) begin
            sel = EXC_RST;
        end else if (chain_q) begin
            sel     = EXC_FIQ;
            base_pc = DABT_BASE;
            base_t  = 1'b0;
            old_psr = '{i: 1'b1, f: 1'b0, t: 1'b0, mode: MODE_ABT};
        end else begin
            sel = win;
        end
    end

    assign chain_nxt = !rst_req && !rq_q && !chain_q && (win == EXC_DABT) && fiq_en;

    always_ff @(posedge clk) begin
        rq_q <= rst_req;
        if (rst) begin
            chain_q     <= 1'b0;
            entry_vld   <= 1'b0;
            entry_kind  <= EXC_NONE;
            entry_vec   <= '0;
            entry_mode  <= '0;
            entry_i     <= 1'b0;
            entry_f     <= 1'b0;
            entry_t     <= 1'b0;
            entry_link  <= '0;
            entry_saved <= '0;
        end else begin
            chain_q    <= chain_nxt;
            entry_vld  <= (sel != EXC_NONE);
            entry_kind <= sel;
            if (sel != EXC_NONE) begin
                entry_vec   <= ADDR_W'(vec_off(sel));
                entry_mode  <= mode_of(sel);
                entry_i     <= 1'b1;
                entry_f     <= (sel == EXC_FIQ || sel == EXC_RST) ? 1'b1 : old_psr.f;
                entry_t     <= 1'b0;
                entry_link  <= (sel == EXC_RST) ? '0 : base_pc + ADDR_W'(link_off(sel, base_t));
                entry_saved <= old_psr;
            end
        end
    end
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              rst_req,
    input logic              boundary,
    input logic              cur_i,
    input logic              cur_f,
    input logic              entry_vld,
    input logic [2:0]        entry_kind,
    input logic [4:0]        entry_mode,
    input logic              entry_i,
    input logic              entry_f,
    input logic              entry_t,
    input logic [ADDR_W-1:0] entry_vec,
    input logic [ADDR_W-1:0] entry_link
);
    // R1
    rst_hold_chk: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !entry_vld);

    // R1
    rst_release_chk: assert property (@(posedge clk) disable iff (rst)
        (!rst_req && $past(rst_req)) |=> (entry_vld && entry_kind == 3'd1 &&
            entry_vec == '0 && entry_mode == 5'b10011 && entry_f));

    // R6
    entry_flags_chk: assert property (@(posedge clk) disable iff (rst)
        entry_vld |-> (entry_i && !entry_t));

    // R8
    irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (entry_vld && entry_kind == 3'd4) |-> $past(!cur_i));

    // R8
    fiq_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (entry_vld && entry_kind == 3'd3 && !$past(entry_vld && entry_kind == 3'd2))
            |-> $past(!cur_f));

    // R10
    boundary_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (!boundary && !rst_req && !$past(rst_req) && !(entry_vld && entry_kind == 3'd2))
            |=> !entry_vld);

    // R11
    chain_link_chk: assert property (@(posedge clk) disable iff (rst)
        (entry_vld && entry_kind == 3'd3 && $past(entry_vld && entry_kind == 3'd2))
            |-> (entry_link == ADDR_W'(5'h14) && entry_mode == 5'b10001));

    // R12
    kind_idle_chk: assert property (@(posedge clk) disable iff (rst)
        entry_vld == (entry_kind != 3'd0));
endmodule

bind exc_entry_ctrl exc_entry_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rst_req    (rst_req),
    .boundary   (boundary),
    .cur_i      (cur_i),
    .cur_f      (cur_f),
    .entry_vld  (entry_vld),
    .entry_kind (entry_kind),
    .entry_mode (entry_mode),
    .entry_i    (entry_i),
    .entry_f    (entry_f),
    .entry_t    (entry_t),
    .entry_vec  (entry_vec),
    .entry_link (entry_link)
);

// File: tb/test_exc_entry_ctrl.sv
module test_exc_entry_ctrl;
    localparam int AW = 16;
    localparam int SS = 3;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst, rst_req, boundary, irq_n, fiq_n, sync_bypass;
    logic dabt_req, pabt_req, und_req, swi_req, cur_i, cur_f, cur_t;
    logic [4:0] cur_mode;
    logic [AW-1:0] cur_pc;
    logic entry_vld, entry_i, entry_f, entry_t;
    logic [2:0] entry_kind;
    logic [AW-1:0] entry_vec, entry_link;
    logic [4:0] entry_mode;
    logic [7:0] entry_saved;

    exc_entry_ctrl #(.ADDR_W(AW), .SYNC_STAGES(SS)) i_exc_entry_ctrl (
        .clk(clk), .rst(rst), .rst_req(rst_req), .boundary(boundary),
        .irq_n(irq_n), .fiq_n(fiq_n), .sync_bypass(sync_bypass),
        .dabt_req(dabt_req), .pabt_req(pabt_req), .und_req(und_req), .swi_req(swi_req),
        .cur_i(cur_i), .cur_f(cur_f), .cur_t(cur_t), .cur_mode(cur_mode), .cur_pc(cur_pc),
        .entry_vld(entry_vld), .entry_kind(entry_kind), .entry_vec(entry_vec),
        .entry_mode(entry_mode), .entry_i(entry_i), .entry_f(entry_f), .entry_t(entry_t),
        .entry_link(entry_link), .entry_saved(entry_saved)
    );

    int total = 0;
    int bad = 0;
    bit done = 0;
    string tag = "R12";

    // reference model state
    int rq_m = 0, chain_m = 0;
    int ip[SS];
    int fp[SS];

    // expected outputs
    int e_vld, e_kind, e_vec, e_mode, e_i, e_f, e_t, e_link, e_saved;

    function automatic int vec_for(int k);
        case (k)
            6: return 'h04; 7: return 'h08; 5: return 'h0C;
            2: return 'h10; 4: return 'h18; 3: return 'h1C;
            default: return 0;
        endcase
    endfunction

    function automatic int mode_for(int k);
        case (k)
            3: return 'b10001; 4: return 'b10010;
            2, 5: return 'b10111; 6: return 'b11011;
            default: return 'b10011;
        endcase
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s/%s %s: actual=%0h expected=%0h at %0t", tag, req, what, act, exp, $time);
        end
    endtask

    task automatic step();
        int ie, fe, fen, ien, k, pc, th, sv, off;
        ie  = sync_bypass ? int'(irq_n) : ip[SS-1];
        fe  = sync_bypass ? int'(fiq_n) : fp[SS-1];
        fen = (fe == 0) && !cur_f;
        ien = (ie == 0) && !cur_i;
        k = 0; pc = int'(cur_pc); th = int'(cur_t);
        sv = {24'd0, cur_i, cur_f, cur_t, cur_mode};
        if (rst || rst_req) k = 0;
        else if (rq_m != 0) k = 1;
        else if (chain_m != 0) begin k = 3; pc = 'h10; th = 0; sv = 'h80 | 'b10111; end
        else if (boundary) begin
            if (dabt_req) k = 2;
            else if (fen != 0) k = 3;
            else if (ien != 0) k = 4;
            else if (pabt_req) k = 5;
            else if (und_req) k = 6;
            else if (swi_req) k = 7;
        end
        e_vld = (k != 0); e_kind = k;
        if (k != 0) begin
            e_vec = vec_for(k); e_mode = mode_for(k); e_i = 1; e_t = 0;
            e_f = (k == 1 || k == 3) ? 1 : ((sv >> 6) & 1);
            off = (k == 2) ? 8 : ((k == 6 || k == 7) && th != 0) ? 2 : 4;
            e_link = (k == 1) ? 0 : ((pc + off) & ((1 << AW) - 1));
            e_saved = sv;
        end
        // next model state
        if (rst) chain_m = 0;
        else chain_m = (!rst_req && rq_m == 0 && chain_m == 0 && boundary && k == 2 && fen != 0);
        rq_m = rst_req;
        for (int s = SS - 1; s > 0; s--) begin
            ip[s] = rst ? 1 : ip[s-1];
            fp[s] = rst ? 1 : fp[s-1];
        end
        ip[0] = rst ? 1 : int'(irq_n);
        fp[0] = rst ? 1 : int'(fiq_n);
        @(posedge clk);
        @(negedge clk);
        if (rst) begin
            chk("R12", "reset vld", int'(entry_vld), 0);
            chk("R12", "reset kind", int'(entry_kind), 0);
            chk("R12", "reset link", int'(entry_link), 0);
            chk("R12", "reset vec", int'(entry_vec), 0);
        end else begin
            chk("R12", "vld", int'(entry_vld), e_vld);
            chk("R12", "kind", int'(entry_kind), e_kind);
            if (e_vld != 0) begin
                chk(k == 1 ? "R1" : "R3", "vec", int'(entry_vec), e_vec);
                chk(k == 1 ? "R1" : "R4", "mode", int'(entry_mode), e_mode);
                chk("R6", "i", int'(entry_i), e_i);
                chk("R6", "f", int'(entry_f), e_f);
                chk("R6", "t", int'(entry_t), e_t);
                chk("R5", "link", int'(entry_link), e_link);
                chk("R7", "saved", int'(entry_saved), e_saved);
            end
        end
    endtask

    task automatic idle();
        boundary = 0; dabt_req = 0; pabt_req = 0; und_req = 0; swi_req = 0;
        irq_n = 1; fiq_n = 1;
    endtask

    initial begin
        rst = 1; rst_req = 1; sync_bypass = 1;
        cur_i = 0; cur_f = 0; cur_t = 0; cur_mode = 5'b10000; cur_pc = '0;
        idle();
        for (int s = 0; s < SS; s++) begin ip[s] = 1; fp[s] = 1; end
        @(negedge clk);
        // R12: reset clears outputs
        tag = "R12";
        repeat (3) step();
        rst = 0;
        // R1: held reset request gives nothing, release gives reset entry
        tag = "R1";
        boundary = 1; dabt_req = 1;
        repeat (2) step();
        rst_req = 0; step(); step();
        idle(); step();

        // single requests, R3 R4 R5
        tag = "R3";
        cur_pc = 16'h0100; cur_t = 1; cur_mode = 5'b10000;
        boundary = 1; und_req = 1; step(); idle(); step();
        cur_t = 0; boundary = 1; swi_req = 1; step(); idle(); step();
        cur_t = 1; boundary = 1; swi_req = 1; step(); idle(); step();
        cur_pc = 16'h2000; boundary = 1; pabt_req = 1; step(); idle(); step();
        cur_f = 1; cur_t = 0; boundary = 1; dabt_req = 1; step(); idle(); step();
        // R5: wrap of link
        tag = "R5";
        cur_pc = 16'hFFFE; boundary = 1; dabt_req = 1; step(); idle(); step();
        cur_f = 0; cur_pc = 16'h0400;

        // R10: no boundary, no entry
        tag = "R10";
        dabt_req = 1; pabt_req = 1; und_req = 1; irq_n = 0; step(); step();
        idle(); step();

        // R2: priority
        tag = "R2";
        cur_f = 1;
        boundary = 1; dabt_req = 1; pabt_req = 1; und_req = 1; irq_n = 0; step();
        idle(); step();
        cur_f = 0;
        boundary = 1; fiq_n = 0; irq_n = 0; pabt_req = 1; step(); idle(); step();
        boundary = 1; irq_n = 0; pabt_req = 1; und_req = 1; step(); idle(); step();
        boundary = 1; pabt_req = 1; und_req = 1; step(); idle(); step();

        // R8: masks
        tag = "R8";
        cur_i = 1; boundary = 1; irq_n = 0; step(); idle(); step();
        cur_i = 0; cur_f = 1; boundary = 1; fiq_n = 0; irq_n = 0; step(); idle(); step();
        cur_f = 0;

        // R9: synchronizer lag versus bypass
        tag = "R9";
        sync_bypass = 0; step(); step(); step(); step();
        boundary = 1; irq_n = 0;
        repeat (SS + 2) step();
        irq_n = 1; repeat (SS + 2) step();
        idle(); fiq_n = 0; step(); step(); boundary = 1; repeat (SS + 1) step();
        idle(); repeat (SS + 1) step();
        sync_bypass = 1; boundary = 1; fiq_n = 0; step(); idle(); step();

        // R11: data abort with enabled fast interrupt chains
        tag = "R11";
        cur_pc = 16'h0800; cur_mode = 5'b10000;
        boundary = 1; dabt_req = 1; fiq_n = 0; step();
        idle(); step(); step();
        // chain with boundary held and a new request in the chain cycle
        boundary = 1; dabt_req = 1; fiq_n = 0; step();
        dabt_req = 0; fiq_n = 1; pabt_req = 1; step(); step();
        idle(); step();

        // R1: reset request during pending requests
        tag = "R1";
        boundary = 1; irq_n = 0; rst_req = 1; step(); step();
        rst_req = 0; step(); step();
        idle(); step(); step();

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule